// File: doc/BRIEF.md
# Floating-Point Rename Table

This block tracks where the live value of every architectural floating-point register can be found. Each register has one entry. An entry of zero means the register file holds the current value. A non-zero entry is the tag of the reservation station that will produce the value. The block also contains the register file.

On an issue request the block looks up two source registers. For each source it returns either the register-file value (marked ready) or the tag of the pending producer. In the same cycle it renames the destination register to the newly allocated station tag.

On a result broadcast the block compares the broadcast tag against every entry. The register whose entry still carries that tag takes the value and has its entry cleared. A register that has since been renamed to a younger producer is left alone. Once an entry is cleared, its tag is free for reuse and readers get the value straight from the register file.

Station tags run from 1 to `NUM_TAGS`; with the default of 5, tags 1–3 stand for adder stations and 4–5 for multiply/divide stations. Tag 0 is reserved for "no producer".

Top module: `fp_rename_table`

## Requirements
- R1: A reset of at least one cycle sets every entry to zero and drives `lk_valid` low; a lookup issued after reset returns ready=1 with the value last written into the register file for each source.
- R2: Lookup results appear one cycle after the issue edge. A source whose entry is zero returns ready=1, the register-file value and tag=0.
- R3: A source whose entry is non-zero, with no matching broadcast in the issue cycle, returns ready=0, value=0 and the entry's tag.
- R4: An issue writes `iss_tag` into the destination entry. Sources of the same issue are looked up before the rename, so a source equal to the destination returns its older mapping.
- R5: A broadcast with a non-zero tag equal to a register's entry writes `bc_data` into that register and clears the entry. Later lookups of that register return ready=1 with `bc_data`.
- R6: A broadcast whose tag no entry holds, such as one from a producer whose register was renamed since, changes no entry. Later lookups still return the younger tag.
- R7: When an issue renames a register in the same cycle that a broadcast matches that register's entry, the entry takes the new issue tag and is not cleared.
- R8: A source looked up in the same cycle as a broadcast matching its entry returns ready=1 with the broadcast data, not the tag.
- R9: A broadcast with `bc_valid` low, or with tag 0, changes no entry and no register-file value.
- R10: `lk_valid` is `iss_valid` delayed by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request this cycle |
| iss_src_a | input | $clog2(NUM_REGS) | First source register |
| iss_src_b | input | $clog2(NUM_REGS) | Second source register |
| iss_dst | input | $clog2(NUM_REGS) | Destination register to rename |
| iss_tag | input | $clog2(NUM_TAGS+1) | Station tag allocated to the issue, 1..NUM_TAGS |
| bc_valid | input | 1 | Result broadcast this cycle |
| bc_tag | input | $clog2(NUM_TAGS+1) | Tag of the broadcasting station |
| bc_data | input | DATA_W | Broadcast result |
| lk_valid | output | 1 | Lookup results below are valid |
| lk_a_ready | output | 1 | First source value is available |
| lk_a_value | output | DATA_W | First source value, 0 when not ready |
| lk_a_tag | output | $clog2(NUM_TAGS+1) | First source producer tag, 0 when ready |
| lk_b_ready | output | 1 | Second source value is available |
| lk_b_value | output | DATA_W | Second source value, 0 when not ready |
| lk_b_tag | output | $clog2(NUM_TAGS+1) | Second source producer tag, 0 when ready |

## Verification
The stimulus fills the register file through issue/broadcast pairs. It then runs a dependent chain in which the same register is renamed twice while its first producer is still outstanding. This separates a guarded writeback from an unguarded one, because a stale broadcast would otherwise erase the younger tag. Further patterns separate the priorities at each collision. Issue and broadcast hitting the same destination in one cycle shows whether the rename beats the clear. A source looked up during its own producer's broadcast shows whether the bypass beats the stale tag. A source equal to the destination shows the lookup-before-rename order. Tag-zero and invalid broadcasts, followed by lookups, show that nothing leaks in. A reset in the middle of the run shows that the mappings are dropped while register-file contents survive.

// File: rtl/rat_pkg.sv
package rat_pkg;

  localparam int unsigned DEF_NUM_REGS = 8;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_NUM_TAGS = 5;

  // Where a looked-up source operand comes from
  typedef enum logic [1:0] {
    SRC_RF     = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_WAIT   = 2'd2
  } src_kind_e;

endpackage

// File: rtl/rat_map_table.sv
module rat_map_table #(
  parameter int unsigned NUM_REGS = rat_pkg::DEF_NUM_REGS,
  parameter int unsigned NUM_TAGS = rat_pkg::DEF_NUM_TAGS,
  localparam int unsigned REG_AW  = $clog2(NUM_REGS),
  localparam int unsigned TAG_W   = $clog2(NUM_TAGS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [REG_AW-1:0] iss_src_a,
  input  logic [REG_AW-1:0] iss_src_b,
  input  logic [REG_AW-1:0] iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  output logic [TAG_W-1:0]  map_a,
  output logic [TAG_W-1:0]  map_b,
  output logic              rf_we,
  output logic [REG_AW-1:0] rf_waddr
);

  logic [TAG_W-1:0]    map_q [NUM_REGS];
  logic [NUM_REGS-1:0] match;
  logic [NUM_REGS-1:0] renamed;
  logic                bc_live;

  assign bc_live = bc_valid && (bc_tag != '0);

  // Sources see the mapping before this cycle's rename
  assign map_a = map_q[iss_src_a];
  assign map_b = map_q[iss_src_b];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_entry
      assign match[gi]   = bc_live && (map_q[gi] == bc_tag);
      assign renamed[gi] = iss_valid && (iss_dst == REG_AW'(gi));

      AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (match[gi] && !renamed[gi]) |=> (map_q[gi] == '0)) else $error("clear"); // R5

      AST_ENTRY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!match[gi] && !renamed[gi]) |=> $stable(map_q[gi])) else $error("hold"); // R6

      AST_RENAME_TAKES: assert property (@(posedge clk) disable iff (rst)
        renamed[gi] |=> (map_q[gi] == $past(iss_tag))) else $error("rename"); // R4

      AST_ISSUE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (renamed[gi] && match[gi]) |=> (map_q[gi] != '0)) else $error("prio"); // R7

      AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (map_q[gi] == '0)) else $error("reset"); // R1
    end
  endgenerate

  // Write port for the guarded register-file update
  always_comb begin
    rf_we    = |match;
    rf_waddr = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (match[i]) rf_waddr = REG_AW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) map_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (renamed[i])    map_q[i] <= iss_tag;
        else if (match[i]) map_q[i] <= '0;
      end
    end
  end

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match)) else $error("dup tag"); // R5

  AST_ISSUE_TAG_RANGE: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> (iss_tag != '0 && iss_tag <= TAG_W'(NUM_TAGS))) else $error("tag"); // R4

endmodule

// File: rtl/rat_regfile.sv
module rat_regfile #(
  parameter int unsigned NUM_REGS = rat_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = rat_pkg::DEF_DATA_W,
  parameter int unsigned NUM_RD   = 2,
  localparam int unsigned REG_AW  = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic [REG_AW-1:0]              waddr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_RD-1:0][REG_AW-1:0]  raddr,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdata
);

  // No reset: plain synchronous memory with registered reads
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_RD; p++) rdata[p] <= mem[raddr[p]];
  end

endmodule

// File: rtl/rat_src_stage.sv
module rat_src_stage #(
  parameter int unsigned DATA_W   = rat_pkg::DEF_DATA_W,
  parameter int unsigned NUM_TAGS = rat_pkg::DEF_NUM_TAGS,
  localparam int unsigned TAG_W   = $clog2(NUM_TAGS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TAG_W-1:0]  map_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              ready,
  output logic [DATA_W-1:0] value,
  output logic [TAG_W-1:0]  tag
);
  import rat_pkg::*;

  src_kind_e         kind_d, kind_q;
  logic [DATA_W-1:0] byp_q;
  logic [TAG_W-1:0]  tag_q;

  always_comb begin
    if (map_tag == '0)                        kind_d = SRC_RF;
    else if (bc_valid && bc_tag == map_tag)   kind_d = SRC_BYPASS;
    else                                      kind_d = SRC_WAIT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= SRC_WAIT;
      byp_q  <= '0;
      tag_q  <= '0;
    end else begin
      kind_q <= kind_d;
      byp_q  <= bc_data;
      tag_q  <= map_tag;
    end
  end

  always_comb begin
    ready = (kind_q != SRC_WAIT);
    tag   = (kind_q == SRC_WAIT) ? tag_q : '0;
    case (kind_q)
      SRC_RF:     value = rf_rdata;
      SRC_BYPASS: value = byp_q;
      default:    value = '0;
    endcase
  end

  AST_BYPASS_HIT: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && map_tag != '0 && bc_tag == map_tag)
      |=> (ready && value == $past(bc_data))) else $error("bypass"); // R8

  AST_PENDING_TAG: assert property (@(posedge clk) disable iff (rst)
    (map_tag != '0 && !(bc_valid && bc_tag == map_tag))
      |=> (!ready && tag == $past(map_tag) && value == '0)) else $error("pending"); // R3

endmodule

// File: rtl/fp_rename_table.sv
module fp_rename_table #(
  parameter int unsigned NUM_REGS = rat_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = rat_pkg::DEF_DATA_W,
  parameter int unsigned NUM_TAGS = rat_pkg::DEF_NUM_TAGS,
  localparam int unsigned REG_AW  = $clog2(NUM_REGS),
  localparam int unsigned TAG_W   = $clog2(NUM_TAGS + 1),
  localparam int unsigned NUM_SRC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [REG_AW-1:0] iss_src_a,
  input  logic [REG_AW-1:0] iss_src_b,
  input  logic [REG_AW-1:0] iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              lk_valid,
  output logic              lk_a_ready,
  output logic [DATA_W-1:0] lk_a_value,
  output logic [TAG_W-1:0]  lk_a_tag,
  output logic              lk_b_ready,
  output logic [DATA_W-1:0] lk_b_value,
  output logic [TAG_W-1:0]  lk_b_tag
);

  logic [TAG_W-1:0]                    map_a, map_b;
  logic                                rf_we;
  logic [REG_AW-1:0]                   rf_waddr;
  logic [NUM_SRC-1:0][REG_AW-1:0]      rd_addr;
  logic [NUM_SRC-1:0][DATA_W-1:0]      rd_data;
  logic [NUM_SRC-1:0][TAG_W-1:0]       src_map;
  logic [NUM_SRC-1:0]                  src_ready;
  logic [NUM_SRC-1:0][DATA_W-1:0]      src_value;
  logic [NUM_SRC-1:0][TAG_W-1:0]       src_tag;

  rat_map_table #(.NUM_REGS(NUM_REGS), .NUM_TAGS(NUM_TAGS)) u_map (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_dst(iss_dst), .iss_tag(iss_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag),
    .map_a(map_a), .map_b(map_b),
    .rf_we(rf_we), .rf_waddr(rf_waddr)
  );

  assign rd_addr[0] = iss_src_a;
  assign rd_addr[1] = iss_src_b;
  assign src_map[0] = map_a;
  assign src_map[1] = map_b;

  rat_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(NUM_SRC)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(bc_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  genvar gs;
  generate
    for (gs = 0; gs < NUM_SRC; gs++) begin : g_src
      rat_src_stage #(.DATA_W(DATA_W), .NUM_TAGS(NUM_TAGS)) u_stage (
        .clk(clk), .rst(rst),
        .map_tag(src_map[gs]),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .rf_rdata(rd_data[gs]),
        .ready(src_ready[gs]), .value(src_value[gs]), .tag(src_tag[gs])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) lk_valid <= 1'b0;
    else     lk_valid <= iss_valid;
  end

  assign lk_a_ready = src_ready[0];
  assign lk_a_value = src_value[0];
  assign lk_a_tag   = src_tag[0];
  assign lk_b_ready = src_ready[1];
  assign lk_b_value = src_value[1];
  assign lk_b_tag   = src_tag[1];

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lk_valid == $past(iss_valid)) else $error("valid"); // R10

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !lk_valid) else $error("reset valid"); // R1

  AST_READY_NO_TAG: assert property (@(posedge clk) disable iff (rst)
    lk_a_ready |-> (lk_a_tag == '0)) else $error("ready tag"); // R2

endmodule

// File: tb/fp_rename_table_bench.sv
`timescale 1ns/1ps
module fp_rename_table_bench;

  typedef struct packed {
    logic        chk;
    logic        iv;
    logic [2:0]  sa;
    logic [2:0]  sb;
    logic [2:0]  dst;
    logic [2:0]  itag;
    logic        bv;
    logic [2:0]  btag;
    logic [31:0] bdata;
    logic        ear;
    logic [31:0] eav;
    logic [2:0]  eat;
    logic        ebr;
    logic [31:0] ebv;
    logic [2:0]  ebt;
  } row_t;

  localparam int NROWS = 21;
  // chk iv sa sb dst itag bv btag bdata | a:rdy val tag | b:rdy val tag
  localparam row_t ROWS [NROWS] = '{
    '{0,1,0,0,0,1, 0,0,32'h0,    0,32'h0,0,     0,32'h0,0},   // fill r0
    '{0,1,0,0,1,2, 1,1,32'h100,  0,32'h0,0,     0,32'h0,0},
    '{0,1,0,0,2,3, 1,2,32'h111,  0,32'h0,0,     0,32'h0,0},
    '{0,1,0,0,3,4, 1,3,32'h122,  0,32'h0,0,     0,32'h0,0},
    '{1,0,0,0,0,0, 1,4,32'h133,  0,32'h0,0,     0,32'h0,0},   // R10 no issue
    '{1,1,0,3,5,1, 0,0,32'h0,    1,32'h100,0,   1,32'h133,0}, // R2
    '{1,1,5,1,6,2, 0,0,32'h0,    0,32'h0,1,     1,32'h111,0}, // R3
    '{1,1,6,6,6,3, 0,0,32'h0,    0,32'h0,2,     0,32'h0,2},   // R4 src==dst
    '{1,1,6,5,7,4, 1,2,32'h222,  0,32'h0,3,     0,32'h0,1},   // R6 stale bc
    '{1,1,5,7,4,2, 1,1,32'h155,  1,32'h155,0,   0,32'h0,4},   // R8 bypass
    '{1,1,5,6,0,1, 0,0,32'h0,    1,32'h155,0,   0,32'h0,3},   // R5 cleared
    '{1,1,2,4,6,5, 1,3,32'h366,  1,32'h122,0,   0,32'h0,2},   // R7 collide
    '{1,1,6,0,1,3, 0,0,32'h0,    0,32'h0,5,     0,32'h0,1},   // R7 tag kept
    '{1,0,0,0,0,0, 1,0,32'hdead, 0,32'h0,0,     0,32'h0,0},   // R9 tag 0
    '{1,0,0,0,0,0, 0,5,32'hbeef, 0,32'h0,0,     0,32'h0,0},   // R9 invalid
    '{1,0,0,0,0,0, 1,4,32'h477,  0,32'h0,0,     0,32'h0,0},
    '{1,1,6,7,7,4, 0,0,32'h0,    0,32'h0,5,     1,32'h477,0}, // R9 / R5
    '{1,0,0,0,0,0, 1,5,32'h588,  0,32'h0,0,     0,32'h0,0},
    '{1,1,6,2,2,5, 0,0,32'h0,    1,32'h588,0,   1,32'h122,0}, // R5
    '{1,0,0,0,0,0, 1,2,32'h2aa,  0,32'h0,0,     0,32'h0,0},
    '{1,1,4,4,5,2, 0,0,32'h0,    1,32'h2aa,0,   1,32'h2aa,0}  // R5
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iss_valid = 1'b0;
  logic [2:0]  iss_src_a = '0, iss_src_b = '0, iss_dst = '0, iss_tag = '0;
  logic        bc_valid = 1'b0;
  logic [2:0]  bc_tag = '0;
  logic [31:0] bc_data = '0;
  logic        lk_valid, lk_a_ready, lk_b_ready;
  logic [31:0] lk_a_value, lk_b_value;
  logic [2:0]  lk_a_tag, lk_b_tag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fp_rename_table u_fp_rename_table (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_dst(iss_dst), .iss_tag(iss_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .lk_valid(lk_valid),
    .lk_a_ready(lk_a_ready), .lk_a_value(lk_a_value), .lk_a_tag(lk_a_tag),
    .lk_b_ready(lk_b_ready), .lk_b_value(lk_b_value), .lk_b_tag(lk_b_tag)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic iv, input logic [2:0] sa, input logic [2:0] sb,
                       input logic [2:0] dst, input logic [2:0] it,
                       input logic bv, input logic [2:0] bt, input logic [31:0] bd);
    @(negedge clk);
    iss_valid = iv; iss_src_a = sa; iss_src_b = sb; iss_dst = dst; iss_tag = it;
    bc_valid = bv; bc_tag = bt; bc_data = bd;
    @(posedge clk);
    #1;
  endtask

  task automatic check_lookup(input string req, input row_t r);
    check(req, "a_ready", 32'(lk_a_ready), 32'(r.ear));
    check(req, "a_value", lk_a_value, r.eav);
    check(req, "a_tag",   32'(lk_a_tag),   32'(r.eat));
    check(req, "b_ready", 32'(lk_b_ready), 32'(r.ebr));
    check(req, "b_value", lk_b_value, r.ebv);
    check(req, "b_tag",   32'(lk_b_tag),   32'(r.ebt));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", "lk_valid after reset", 32'(lk_valid), 32'd0);

    for (int i = 0; i < NROWS; i++) begin
      drive(ROWS[i].iv, ROWS[i].sa, ROWS[i].sb, ROWS[i].dst, ROWS[i].itag,
            ROWS[i].bv, ROWS[i].btag, ROWS[i].bdata);
      if (ROWS[i].chk) begin
        check("R10", $sformatf("lk_valid row %0d", i), 32'(lk_valid), 32'(ROWS[i].iv));
        if (ROWS[i].iv) check_lookup($sformatf("R2-R9 row %0d", i), ROWS[i]);
      end
    end

    // R1: mid-run reset drops mappings but keeps register-file contents
    @(negedge clk);
    iss_valid = 1'b0; bc_valid = 1'b0; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", "lk_valid during reset", 32'(lk_valid), 32'd0);
    drive(1'b1, 3'd7, 3'd2, 3'd0, 3'd1, 1'b0, 3'd0, 32'h0);
    check("R1", "r7 ready", 32'(lk_a_ready), 32'd1);
    check("R1", "r7 value", lk_a_value, 32'h477);
    check("R1", "r2 ready", 32'(lk_b_ready), 32'd1);
    check("R1", "r2 value", lk_b_value, 32'h122);

    // R8 on port b plus R4: r0 now maps tag 1
    drive(1'b1, 3'd3, 3'd0, 3'd3, 3'd2, 1'b1, 3'd1, 32'h9a9);
    check("R8", "b bypass ready", 32'(lk_b_ready), 32'd1);
    check("R8", "b bypass value", lk_b_value, 32'h9a9);
    check("R4", "a old mapping of dst", lk_a_value, 32'h133);
    drive(1'b1, 3'd3, 3'd0, 3'd4, 3'd3, 1'b0, 3'd0, 32'h0);
    check("R4", "renamed r3 tag", 32'(lk_a_tag), 32'd2);
    check("R5", "r0 from rf", lk_b_value, 32'h9a9);
    drive(1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, 32'h0);
    check("R10", "lk_valid drops", 32'(lk_valid), 32'd0);

    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule